// File: doc/BRIEF.md
# Zero-Crossing Triggered Pulse Sequencer

This block converts conditioned sensor events into a single-bit pulse-width-modulated output. Each rising edge on an asynchronous crossing strobe arms one output pulse. The pulse begins a fixed number of clock ticks after the crossing. Its length comes from a small table indexed by a 2-bit amplitude level and a 1-bit direction flag, and that table is sampled at the moment the pulse begins.

One counter times every phase of the sequence: the delay before the pulse, the pulse itself, the watchdog interval that ends in a STOP pulse when crossings cease, and the STOP pulse. A qualifier input marks whether the upstream peak tracker has finished acquiring the signal. Until it has, the output stays low and crossings are ignored.

A crossing that lands while a pulse is high is remembered and starts a new delay when that pulse ends. A crossing that lands during the delay phase restarts the delay.

Top module: `zc_pulse_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `pulse_o` is low.
- R2: The crossing strobe passes through a two-flop synchronizer and an edge detector. The leading edge of a pulse appears on the rising clock edge that is DLY_TICKS+3 edges after the first edge that samples the strobe high.
- R3: The pulse stays high for BASE_TICKS + amp*STEP_TICKS + dir*DIR_TICKS clock cycles. Here amp is `amp_i` read as an unsigned number 0..3 and dir is `dir_i` (1 adds DIR_TICKS). With default parameters this gives 60, 90, 120 and 150 cycles for dir 0, and 180, 210, 240 and 270 cycles for dir 1.
- R4: `amp_i` and `dir_i` are sampled only on the edge where the pulse begins. Changes during the delay before that edge take effect, and changes while the pulse is high have no effect on its length.
- R5: A crossing during a pulse is held as pending. The next pulse begins DLY_TICKS cycles after the falling edge. Several crossings within one pulse yield only one extra pulse.
- R6: A crossing during the delay phase restarts the delay from zero.
- R7: If no crossing arrives for TMO_TICKS cycles, a STOP pulse of STOP_TICKS cycles is emitted. The watchdog interval is counted from the fall of the previous pulse, or from the first qualified cycle. STOP pulses repeat with the same gap while crossings stay absent.
- R8: While `acq_ok_i` is low, `pulse_o` is low on the following cycle, crossings are discarded, and the sequence returns to idle with its counter at zero.
- R9: A strobe held high for many cycles counts as one crossing.
- R10: A crossing during a STOP pulse is held as pending and starts a delay when the STOP pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_i | input | 1 | Asynchronous zero-crossing strobe, rising edge significant |
| amp_i | input | 2 | Decoded amplitude level |
| dir_i | input | 1 | Direction flag |
| acq_ok_i | input | 1 | Peak acquisition complete; low blanks the output |
| pulse_o | output | 1 | Registered PWM output |

## Verification
The embedded properties check, on every cycle, the following:
- the synchronizer never gives two events in a row;
- the watchdog count stays below its limit;
- the latched width stays constant and is never exceeded while a pulse is high;
- a pulse is entered only from the last delay tick;
- the output drops the cycle after the qualifier falls.

Only the bench scenarios can show the end-to-end timing from the strobe pin to the output edge, including:
- the full width table;
- when amplitude and direction are sampled;
- the pending and restart rules;
- the STOP cadence.

// File: rtl/zps_pkg.sv
package zps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2,
    ST_STOP  = 2'd3
  } zps_state_e;

endpackage

// File: rtl/zps_sync.sv
module zps_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic evt_o
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign evt_o = sync_q & ~prev_q;

  // R9: a level held high yields a single-cycle event
  p_single_evt_r9: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);

endmodule

// File: rtl/zps_width_rom.sv
module zps_width_rom #(
  parameter int AMP_W      = 2,
  parameter int CNT_W      = 19,
  parameter int BASE_TICKS = 60,
  parameter int STEP_TICKS = 30,
  parameter int DIR_TICKS  = 120
) (
  input  logic [AMP_W-1:0] amp_i,
  input  logic             dir_i,
  output logic [CNT_W-1:0] width_o
);

  localparam int LEVELS  = 2 ** AMP_W;
  localparam int ENTRIES = 2 * LEVELS;

  logic [CNT_W-1:0] table_w [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign table_w[i] = CNT_W'(BASE_TICKS + (i % LEVELS) * STEP_TICKS
                               + (i / LEVELS) * DIR_TICKS);
  end

  assign width_o = table_w[{dir_i, amp_i}];

endmodule

// File: rtl/zps_seq.sv
module zps_seq
  import zps_pkg::*;
#(
  parameter int CNT_W      = 19,
  parameter int DLY_TICKS  = 45,
  parameter int TMO_TICKS  = 745,
  parameter int STOP_TICKS = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             acq_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o
);

  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DLY_TICKS - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_TICKS - 1);
  localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_TICKS - 1);

  zps_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] wid_q, wid_n;
  logic             pend_q, pend_n;
  logic             pulse_q;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q + 1'b1;
    wid_n  = wid_q;
    pend_n = pend_q;
    if (!acq_i) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      pend_n = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (evt_i) begin
            st_n  = ST_DELAY;
            cnt_n = '0;
          end else if (cnt_q == TMO_LAST) begin
            st_n  = ST_STOP;
            cnt_n = '0;
          end
        end
        ST_DELAY: begin
          if (evt_i) begin
            cnt_n = '0;
          end else if (cnt_q == DLY_LAST) begin
            st_n  = ST_PULSE;
            cnt_n = '0;
            wid_n = width_i;
          end
        end
        ST_PULSE, ST_STOP: begin
          if (evt_i) pend_n = 1'b1;
          if ((st_q == ST_PULSE && cnt_q == wid_q - 1'b1) ||
              (st_q == ST_STOP && cnt_q == STOP_LAST)) begin
            cnt_n  = '0;
            pend_n = 1'b0;
            st_n   = (pend_q || evt_i) ? ST_DELAY : ST_IDLE;
          end
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wid_q   <= '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      wid_q   <= wid_n;
      pend_q  <= pend_n;
      pulse_q <= (st_n == ST_PULSE) || (st_n == ST_STOP);
    end
  end

  assign pulse_o = pulse_q;

  // R7: watchdog count never reaches its limit while idle
  p_wdog_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (cnt_q <= TMO_LAST));

  // R3: a pulse never outlasts its latched width
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PULSE) |-> (cnt_q < wid_q));

  // R4: latched width is stable for the whole pulse
  p_width_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PULSE && $past(st_q) == ST_PULSE) |-> $stable(wid_q));

  // R2: a pulse starts only from the final delay tick
  p_lead_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PULSE && $past(st_q) != ST_PULSE) |->
      ($past(st_q) == ST_DELAY && $past(cnt_q) == DLY_LAST));

endmodule

// File: rtl/zc_pulse_seq.sv
module zc_pulse_seq #(
  parameter int AMP_W      = 2,
  parameter int CNT_W      = 19,
  parameter int DLY_TICKS  = 45,
  parameter int TMO_TICKS  = 745,
  parameter int STOP_TICKS = 300,
  parameter int BASE_TICKS = 60,
  parameter int STEP_TICKS = 30,
  parameter int DIR_TICKS  = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             dir_i,
  input  logic             acq_ok_i,
  output logic             pulse_o
);

  logic             zc_evt;
  logic [CNT_W-1:0] width_sel;

  zps_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(zc_i),
    .evt_o  (zc_evt)
  );

  zps_width_rom #(
    .AMP_W     (AMP_W),
    .CNT_W     (CNT_W),
    .BASE_TICKS(BASE_TICKS),
    .STEP_TICKS(STEP_TICKS),
    .DIR_TICKS (DIR_TICKS)
  ) u_rom (
    .amp_i  (amp_i),
    .dir_i  (dir_i),
    .width_o(width_sel)
  );

  zps_seq #(
    .CNT_W     (CNT_W),
    .DLY_TICKS (DLY_TICKS),
    .TMO_TICKS (TMO_TICKS),
    .STOP_TICKS(STOP_TICKS)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (zc_evt),
    .acq_i  (acq_ok_i),
    .width_i(width_sel),
    .pulse_o(pulse_o)
  );

  // R8: losing acquisition blanks the output on the next cycle
  p_blank_r8: assert property (@(posedge clk) disable iff (rst)
    !acq_ok_i |=> !pulse_o);

  // R1: output is low right after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !pulse_o);

endmodule

// File: tb/sim_zc_pulse_seq.sv
module sim_zc_pulse_seq;

  localparam int DLY  = 45;
  localparam int TMO  = 745;
  localparam int STW  = 300;

  // {dir, amp[1:0], width[8:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 2'd2, 9'd120}, {1'b1, 2'd0, 9'd180},
    {1'b0, 2'd0, 9'd60},  {1'b1, 2'd3, 9'd270},
    {1'b0, 2'd3, 9'd150}, {1'b1, 2'd1, 9'd210},
    {1'b0, 2'd1, 9'd90},  {1'b1, 2'd2, 9'd240}
  };

  logic clk = 1'b0;
  logic rst, zc_i, dir_i, acq_ok_i;
  logic [1:0] amp_i;
  logic pulse_o;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  zc_pulse_seq u0 (
    .clk(clk), .rst(rst), .zc_i(zc_i), .amp_i(amp_i),
    .dir_i(dir_i), .acq_ok_i(acq_ok_i), .pulse_o(pulse_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_high(input int drop_at, output int n);
    n = 0;
    while (!pulse_o && n < 5000) begin
      tick(); n++;
      if (n == drop_at) zc_i = 1'b0;
    end
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (pulse_o && n < 5000) begin tick(); n++; end
  endtask

  task automatic count_high(input int span, output int h);
    h = 0;
    for (int i = 0; i < span; i++) begin tick(); if (pulse_o) h++; end
  endtask

  int lat, wid, hi;

  initial begin
    rst = 1'b1; zc_i = 1'b0; amp_i = 2'd0; dir_i = 1'b0; acq_ok_i = 1'b0;
    repeat (4) tick();
    check("R1 reset low", pulse_o, 0);
    rst = 1'b0;
    tick();
    check("R1 low after reset", pulse_o, 0);

    // R8: crossings ignored before acquisition
    zc_i = 1'b1;
    count_high(400, hi);
    zc_i = 1'b0;
    check("R8 blanked before acquisition", hi, 0);

    // R7: first STOP counted from qualification
    acq_ok_i = 1'b1;
    wait_high(-1, lat);
    check("R7 stop after qualify", lat, TMO);
    wait_low(wid);
    check("R7 stop width", wid, STW);

    // R2 R3: width table walk
    for (int v = 0; v < 8; v++) begin
      dir_i = VEC[v][11]; amp_i = VEC[v][10:9];
      zc_i = 1'b1;
      wait_high(3, lat);
      check("R2 latency", lat, DLY + 3);
      wait_low(wid);
      check("R3 width", wid, int'(VEC[v][8:0]));
    end

    // R4: sampled at leading edge only
    amp_i = 2'd0; dir_i = 1'b0; zc_i = 1'b1;
    lat = 0;
    while (!pulse_o && lat < 5000) begin
      tick(); lat++;
      if (lat == 3) zc_i = 1'b0;
      if (lat == 5) begin amp_i = 2'd3; dir_i = 1'b1; end
    end
    check("R4 latency", lat, DLY + 3);
    wid = 0;
    while (pulse_o && wid < 5000) begin
      tick(); wid++;
      if (wid == 10) begin amp_i = 2'd0; dir_i = 1'b0; end
    end
    check("R4 width from leading-edge sample", wid, 270);

    // R6: crossing in delay restarts it
    amp_i = 2'd1; dir_i = 1'b0; zc_i = 1'b1;
    lat = 0;
    while (!pulse_o && lat < 5000) begin
      tick(); lat++;
      if (lat == 3 || lat == 13) zc_i = 1'b0;
      if (lat == 10) zc_i = 1'b1;
    end
    check("R6 restarted delay", lat, DLY + 13);
    wait_low(wid);
    check("R6 width", wid, 90);

    // R5: pending crossings during a pulse
    amp_i = 2'd0; zc_i = 1'b1;
    wait_high(3, lat);
    wid = 0;
    while (pulse_o && wid < 5000) begin
      tick(); wid++;
      if (wid == 5 || wid == 12) zc_i = 1'b1;
      if (wid == 8 || wid == 15) zc_i = 1'b0;
    end
    check("R5 first width", wid, 60);
    wait_high(-1, lat);
    check("R5 gap from fall", lat, DLY);
    wait_low(wid);
    check("R5 second width", wid, 60);
    count_high(400, hi);
    check("R5 single extra pulse", hi, 0);

    // R7: STOP cadence from previous fall (count_high consumed 400)
    wait_high(-1, lat);
    check("R7 stop gap", lat + 400, TMO);
    wait_low(wid);
    check("R7 stop width", wid, STW);
    // R10: crossing during STOP is pending
    wait_high(-1, lat);
    check("R7 repeat gap", lat, TMO);
    wid = 0;
    while (pulse_o && wid < 5000) begin
      tick(); wid++;
      if (wid == 5) zc_i = 1'b1;
      if (wid == 8) zc_i = 1'b0;
    end
    check("R10 stop width", wid, STW);
    amp_i = 2'd2; dir_i = 1'b1;
    wait_high(-1, lat);
    check("R10 delay after stop", lat, DLY);
    wait_low(wid);
    check("R10 pulse width", wid, 240);

    // R9: held strobe gives one pulse
    amp_i = 2'd0; dir_i = 1'b0; zc_i = 1'b1;
    wait_high(-1, lat);
    check("R9 latency", lat, DLY + 3);
    wait_low(wid);
    check("R9 width", wid, 60);
    count_high(400, hi);
    check("R9 no repeat while held", hi, 0);
    zc_i = 1'b0;

    // R8: drop qualifier mid-delay
    tick();
    zc_i = 1'b1;
    repeat (3) tick();
    zc_i = 1'b0;
    repeat (7) tick();
    acq_ok_i = 1'b0;
    count_high(300, hi);
    check("R8 delay aborted", hi, 0);
    acq_ok_i = 1'b1;
    wait_high(-1, lat);
    check("R8 idle restart leads to stop", lat, TMO);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule